// File: doc/BRIEF.md
# SPI Slave Frame Front-End

This block is the serial receive and transmit edge of a register device that holds four channels. A fast system clock oversamples the four serial pins (SCK, chip select, SI and the pause input) through synchronizers, and edge detection on the synchronized SCK drives all the shifting. Each frame opens with an identification byte that carries a fixed device type and a two-bit address. That byte is compared against the address strap inputs. Only on a match does the frame go on to an instruction byte and any number of later bytes. The front end decodes no commands. It hands each completed byte to a command executor with a position index, and it splits the instruction byte into its opcode, register select and channel select fields. On request it shifts one byte out on SO.

The executor sees a start strobe when chip select falls and a per-byte completion strobe. When chip select rises it sees an end strobe, together with a flag that tells whether the frame was accepted and ended on a byte boundary. A low level on the pause input, taken while SCK is low, freezes the sequence so that a shared bus can be used elsewhere. Raising it again, while SCK is low, resumes the frame where it stopped.

Top module: `spi_frame_frontend`

## Requirements
- R1: SI is sampled on each rising SCK edge while the frame runs, most significant bit first. After eight such edges, byteDone pulses for one cycle and rxByte holds the assembled byte.
- R2: The identification byte must read 0101 in bits 7..4, 00 in bits 3..2 and the addrStrap value in bits 1..0. Only then is byteDone raised for it and the frame continued.
- R3: After an identification mismatch, the block ignores all SCK edges until chip select rises. It raises no byteDone, never enables SO, and reports frameWhole as 0.
- R4: While csN is high, soEn is 0. When csN rises after a frame started, frameEnd pulses for one cycle.
- R5: After reset no frame is accepted until csN has been seen high and then falls. A frame already selected during reset produces no strobes.
- R6: byteNum marks each byteDone with its position: 0 for the identification byte, 1 for the instruction byte, 2 for the first data byte and 3 for every later byte.
- R7: txReq and txData are taken on the first SCK falling edge after the instruction byte completes. If txReq is 1, SO carries txData MSB first for the next byte only, changing after falling SCK edges, with soEn high. Otherwise soEn stays 0.
- R8: holdN low, taken while SCK is low, pauses the frame. SCK edges are then ignored and soEn is 0. holdN high, taken while SCK is low, resumes the frame with its bit and byte position kept.
- R9: On frameEnd, frameWhole is 1 only if the frame was accepted, at least one byte completed, and no partial byte was pending.
- R10: frameStart pulses for one cycle on each falling edge of csN.
- R11: At the instruction byte's completion, instrOp takes bits 7..4, instrReg bits 3..2 and instrPot bits 1..0 of that byte. The fields hold until the next instruction byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idles low |
| csN | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| holdN | input | 1 | Pause input, active low |
| addrStrap | input | 2 | Device address straps |
| txReq | input | 1 | Executor asks for a byte to be returned |
| txData | input | 8 | Byte to return on SO |
| so | output | 1 | Serial data out value |
| soEn | output | 1 | Output enable for the SO pad (0 means high impedance) |
| frameStart | output | 1 | Pulse on chip select falling |
| frameEnd | output | 1 | Pulse on chip select rising after a frame |
| frameWhole | output | 1 | Accepted frame with whole bytes, valid from frameEnd |
| byteDone | output | 1 | Pulse on each accepted completed byte |
| byteNum | output | 2 | Position of the completed byte, saturating at 3 |
| rxByte | output | 8 | Last assembled byte |
| instrOp | output | 4 | Opcode field of the instruction byte |
| instrReg | output | 2 | Register select field of the instruction byte |
| instrPot | output | 2 | Channel select field of the instruction byte |

## Verification
The assertions assume that each serial pin holds a level for several system clocks. In particular, chip select is not released and reasserted within one cycle of an end strobe, and the strap inputs stay fixed while a frame runs. The bench keeps each SCK phase eight system clocks long and changes SI only at falling SCK. It moves holdN and csN only while SCK is low and several cycles away from any SCK edge, and it sets the straps and the return request before chip select falls. Within those limits it sweeps every strap and address pair, every corrupted fixed bit, every opcode and several return patterns.

// File: rtl/sff_pkg.sv
package sff_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ABORT = 2'd2
  } frameState_t;

  // Strobes from the control to the datapath, one system cycle wide.
  typedef struct packed {
    logic capture;     // shift SI into the receive register
    logic latchInstr;  // keep the completed instruction byte
    logic load;        // load the return byte into the send register
    logic shift;       // advance the send register by one bit
  } dpStrobes_t;
endpackage

// File: rtl/sff_sync.sv
module sff_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,   // must be 2 or more
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{RST_VAL[b]}};
      else       chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/sff_ctrl.sv
module sff_ctrl
  import sff_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter logic [TYPE_W-1:0] DEV_TYPE = 4'b0101,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckS,
  input  logic              csS,
  input  logic              holdS,
  input  logic [ADDR_W-1:0] strap,
  input  logic [BYTE_W-1:0] rxNext,
  input  logic              txReq,
  output dpStrobes_t        stb,
  output logic              soEn,
  output logic              frameStart,
  output logic              frameEnd,
  output logic              frameWhole,
  output logic              byteDone,
  output logic [1:0]        byteNum
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int PAD_W = BYTE_W - TYPE_W - ADDR_W;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  frameState_t      state;
  logic             sckPrev, csPrev, holdActive, soActive;
  logic [BIT_W-1:0] bitCnt;
  logic [1:0]       byteCnt;
  logic             sckRise, sckFall, csFall, csRise, gate, lastBit, idOk;

  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign csFall  = csPrev & ~csS;
  assign csRise  = ~csPrev & csS;
  assign lastBit = (bitCnt == LAST_BIT);
  assign gate    = (state == ST_RUN) && !holdActive && !csFall && !csRise;

  assign idOk = (rxNext[BYTE_W-1 -: TYPE_W] == DEV_TYPE) &&
                (rxNext[ADDR_W +: PAD_W] == '0) &&
                (rxNext[ADDR_W-1:0] == strap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csPrev  <= 1'b0;   // selected until a real high is seen
    end else begin
      sckPrev <= sckS;
      csPrev  <= csS;
    end
  end

  // Pause level follows holdN only while SCK is low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      holdActive <= 1'b0;
    else if (csS)   holdActive <= 1'b0;
    else if (!sckS) holdActive <= !holdS;
  end

  always_comb begin
    stb            = '0;
    stb.capture    = gate && sckRise;
    stb.latchInstr = gate && sckRise && lastBit && (byteCnt == 2'd1);
    stb.load       = gate && sckFall && (bitCnt == '0) && (byteCnt == 2'd2) && txReq;
    stb.shift      = gate && sckFall && soActive && (bitCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      byteCnt    <= '0;
      soActive   <= 1'b0;
      frameStart <= 1'b0;
      frameEnd   <= 1'b0;
      frameWhole <= 1'b0;
      byteDone   <= 1'b0;
      byteNum    <= '0;
    end else begin
      frameStart <= 1'b0;
      frameEnd   <= 1'b0;
      byteDone   <= 1'b0;
      if (csFall) begin
        state      <= ST_RUN;
        bitCnt     <= '0;
        byteCnt    <= '0;
        soActive   <= 1'b0;
        frameStart <= 1'b1;
      end else if (csRise) begin
        if (state != ST_IDLE) begin
          frameEnd   <= 1'b1;
          frameWhole <= (state == ST_RUN) && (bitCnt == '0) && (byteCnt != '0);
        end
        state    <= ST_IDLE;
        soActive <= 1'b0;
      end else if (gate && sckRise) begin
        if (lastBit) begin
          bitCnt <= '0;
          if ((byteCnt == '0) && !idOk) begin
            state <= ST_ABORT;
          end else begin
            byteDone <= 1'b1;
            byteNum  <= byteCnt;
            if (byteCnt != 2'd3) byteCnt <= byteCnt + 2'd1;
          end
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else if (gate && sckFall && (bitCnt == '0)) begin
        soActive <= stb.load;
      end
    end
  end

  assign soEn = soActive && (state == ST_RUN) && !holdActive && !csS;

  a_r3_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ABORT) |=> !byteDone);
  a_r10_start_runs: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (state == ST_RUN));
  a_r4_end_deselected: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> csS);
  a_r8_hold_no_byte: assert property (@(posedge clk) disable iff (!rstN)
    holdActive |=> !byteDone);
  a_r7_strobes_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capture, stb.load, stb.shift}));
endmodule

// File: rtl/sff_datapath.sv
module sff_datapath
  import sff_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        stb,
  input  logic              siS,
  input  logic [BYTE_W-1:0] txData,
  output logic [BYTE_W-1:0] rxNext,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] instrByte,
  output logic              so
);
  logic [BYTE_W-1:0] rxShift, txShift;

  assign rxNext = {rxShift[BYTE_W-2:0], siS};
  assign rxByte = rxShift;
  assign so     = txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      instrByte <= '0;
      txShift   <= '0;
    end else begin
      if (stb.capture)    rxShift   <= rxNext;
      if (stb.latchInstr) instrByte <= rxNext;
      if (stb.load)       txShift   <= txData;
      else if (stb.shift) txShift   <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  a_r1_rx_steady: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(rxShift));
  a_r7_tx_steady: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.load || stb.shift) |=> $stable(txShift));
endmodule

// File: rtl/spi_frame_frontend.sv
module spi_frame_frontend
  import sff_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OP_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sck,
  input  logic             csN,
  input  logic             si,
  input  logic             holdN,
  input  logic [SEL_W-1:0] addrStrap,
  input  logic             txReq,
  input  logic [BYTE_W-1:0] txData,
  output logic             so,
  output logic             soEn,
  output logic             frameStart,
  output logic             frameEnd,
  output logic             frameWhole,
  output logic             byteDone,
  output logic [1:0]       byteNum,
  output logic [BYTE_W-1:0] rxByte,
  output logic [OP_W-1:0]  instrOp,
  output logic [SEL_W-1:0] instrReg,
  output logic [SEL_W-1:0] instrPot
);
  localparam logic [3:0] SYNC_RST = 4'b1000;  // holdN idles high

  logic [3:0]        pinS;
  logic              sckS, csS, siS, holdS;
  dpStrobes_t        stb;
  logic [BYTE_W-1:0] rxNext, instrByte;

  sff_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN), .din({holdN, si, csN, sck}), .dout(pinS));
  assign {holdS, siS, csS, sckS} = pinS;

  sff_ctrl #(.TYPE_W(OP_W), .DEV_TYPE(4'b0101), .ADDR_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckS(sckS), .csS(csS), .holdS(holdS),
    .strap(addrStrap), .rxNext(rxNext), .txReq(txReq), .stb(stb),
    .soEn(soEn), .frameStart(frameStart), .frameEnd(frameEnd),
    .frameWhole(frameWhole), .byteDone(byteDone), .byteNum(byteNum));

  sff_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .siS(siS), .txData(txData),
    .rxNext(rxNext), .rxByte(rxByte), .instrByte(instrByte), .so(so));

  assign instrOp  = instrByte[BYTE_W-1 -: OP_W];
  assign instrReg = instrByte[SEL_W +: SEL_W];
  assign instrPot = instrByte[SEL_W-1:0];

  a_r2_id_accepted: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && byteNum == 2'd0) |->
      (rxByte[7:4] == 4'b0101 && rxByte[3:2] == 2'b00 && rxByte[1:0] == addrStrap));
endmodule

// File: tb/spi_frame_frontend_tb.sv
module spi_frame_frontend_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, sck = 1'b0, csN = 1'b0, si = 1'b0, holdN = 1'b1;
  logic [1:0] addrStrap = 2'd0;
  logic txReq = 1'b0;
  logic [7:0] txData = 8'h00;
  logic so, soEn, frameStart, frameEnd, frameWhole, byteDone;
  logic [1:0] byteNum, instrReg, instrPot;
  logic [7:0] rxByte;
  logic [3:0] instrOp;

  int checks = 0, errors = 0;
  int nDone = 0, nStart = 0, nEnd = 0, lastNum = -1, lastByte = -1, lastWhole = -1;
  logic soSeen = 1'b0, smpEn, smpSo, anyEn, allEn;
  logic [7:0] soCap;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  spi_frame_frontend u_dut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si), .holdN(holdN),
    .addrStrap(addrStrap), .txReq(txReq), .txData(txData), .so(so), .soEn(soEn),
    .frameStart(frameStart), .frameEnd(frameEnd), .frameWhole(frameWhole),
    .byteDone(byteDone), .byteNum(byteNum), .rxByte(rxByte),
    .instrOp(instrOp), .instrReg(instrReg), .instrPot(instrPot));

  always @(negedge clk) begin
    if (rstN) begin
      if (byteDone) begin nDone++; lastNum = int'(byteNum); lastByte = int'(rxByte); end
      if (frameStart) nStart++;
      if (frameEnd) begin nEnd++; lastWhole = int'(frameWhole); end
      if (soEn) soSeen = 1'b1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clrMon();
    nDone = 0; nStart = 0; nEnd = 0; lastNum = -1; lastByte = -1; lastWhole = -1;
    soSeen = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    si = b;
    repeat (HALF) @(negedge clk);
    smpEn = soEn; smpSo = so;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    anyEn = 1'b0; allEn = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sendBit(v[i]);
      soCap[i] = smpSo; anyEn |= smpEn; allEn &= smpEn;
    end
  endtask

  task automatic csLow();
    clrMon();
    csN = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [7:0] idOf(input logic [1:0] a);
    return {4'b0101, 2'b00, a};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R5: selected already during reset
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 reset soEn", int'(soEn), 0);
    chk("R9 reset byteDone", int'(byteDone), 0);
    chk("R4 reset frameEnd", int'(frameEnd), 0);
    clrMon();
    sendByte(idOf(2'd0));
    sendByte(8'h90);
    chk("R5 no bytes without cs fall", nDone, 0);
    chk("R5 no start without cs fall", nStart, 0);
    csHigh();
    chk("R4 no end without start", nEnd, 0);

    // R2 sweep of straps against addresses
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 4; a++) begin
        addrStrap = 2'(s);
        csLow();
        sendByte(idOf(2'(a)));
        sendByte(8'hA4);
        chk("R2 id accepted count", nDone, (a == s) ? 2 : 0);
        chk("R10 start pulse", nStart, 1);
        csHigh();
        chk("R4 end pulse", nEnd, 1);
        chk("R9 whole after id check", lastWhole, (a == s) ? 1 : 0);
        chk("R4 so idle", int'(soEn), 0);
      end
    end

    // R2 corrupted fixed bits
    addrStrap = 2'd2;
    for (int k = 2; k < 8; k++) begin
      csLow();
      sendByte(idOf(2'd2) ^ 8'(1 << k));
      sendByte(idOf(2'd2));
      chk("R2 fixed bit mismatch", nDone, 0);
      csHigh();
    end

    // R11 and R6 instruction field sweep
    for (int op = 0; op < 16; op++) begin
      logic [7:0] ib;
      ib = {4'(op), 2'(op), ~2'(op)};
      csLow();
      sendByte(idOf(2'd2));
      sendByte(ib);
      chk("R6 instruction index", lastNum, 1);
      chk("R1 instruction byte", lastByte, int'(ib));
      chk("R11 op field", int'(instrOp), op);
      chk("R11 reg field", int'(instrReg), op % 4);
      chk("R11 pot field", int'(instrPot), 3 - (op % 4));
      csHigh();
    end

    // R1/R6/R9 write frame
    csLow();
    sendByte(idOf(2'd2)); sendByte(8'hC4); sendByte(8'hA5);
    chk("R6 data index", lastNum, 2);
    chk("R1 data byte", lastByte, 8'hA5);
    chk("R7 no drive without request", int'(soSeen), 0);
    csHigh();
    chk("R9 whole write frame", lastWhole, 1);

    // R7 read frames
    foreach (txData[i]) ;
    for (int t = 0; t < 5; t++) begin
      logic [7:0] pat;
      case (t)
        0: pat = 8'h00; 1: pat = 8'hFF; 2: pat = 8'h5A; 3: pat = 8'h81; default: pat = 8'h3C;
      endcase
      txReq = 1'b1; txData = pat;
      csLow();
      sendByte(idOf(2'd2)); sendByte(8'hB5);
      chk("R7 quiet before data", int'(soSeen), 0);
      sendByte(8'h00);
      chk("R7 returned byte", int'(soCap), int'(pat));
      chk("R7 enabled whole byte", int'(allEn), 1);
      sendByte(8'h11);
      chk("R7 off after one byte", int'(anyEn), 0);
      chk("R6 saturate fourth", lastNum, 3);
      sendByte(8'h22);
      chk("R6 saturate fifth", lastNum, 3);
      csHigh();
      chk("R4 off after deselect", int'(soEn), 0);
      txReq = 1'b0;
    end

    // R9 partial byte
    csLow();
    sendByte(idOf(2'd2)); sendByte(8'hC4);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    csHigh();
    chk("R9 partial frame", lastWhole, 0);

    // R3 abort with request pending
    txReq = 1'b1; txData = 8'hF0;
    csLow();
    sendByte(idOf(2'd1)); sendByte(idOf(2'd2)); sendByte(8'hB5); sendByte(8'h00);
    chk("R3 no bytes after abort", nDone, 0);
    chk("R3 so never driven", int'(soSeen), 0);
    csHigh();
    chk("R3 frame not whole", lastWhole, 0);
    chk("R3 end still pulses", nEnd, 1);

    // R8 hold in the middle of a read byte
    txData = 8'hC3;
    csLow();
    sendByte(idOf(2'd2)); sendByte(8'hB5);
    sendBit(1'b1); soCap[7] = smpSo;
    sendBit(1'b0); soCap[6] = smpSo;
    sendBit(1'b0); soCap[5] = smpSo;
    repeat (4) @(negedge clk);
    holdN = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 so off in hold", int'(soEn), 0);
    for (int i = 0; i < 3; i++) begin
      si = 1'b1; sck = 1'b1; repeat (HALF) @(negedge clk);
      sck = 1'b0; repeat (HALF) @(negedge clk);
    end
    holdN = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 so back after hold", int'(soEn), 1);
    for (int i = 4; i >= 0; i--) begin
      sendBit(i == 4 || i == 2 || i == 1);
      soCap[i] = smpSo;
    end
    chk("R8 byte count kept", nDone, 3);
    chk("R8 data ignores held edges", lastByte, 8'h96);
    chk("R8 return byte intact", int'(soCap), 8'hC3);
    csHigh();
    chk("R8 whole after hold", lastWhole, 1);
    txReq = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule